// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request from a 32-lane warp and reduces it to the smallest set of aligned memory transactions. Each lane supplies an enable bit and the byte address of a 4-byte word. All enabled lanes whose addresses fall in the same aligned segment are grouped into a single transaction. A transaction carries the segment base address, the segment size and a 32-bit mask of the lanes it serves. A mode bit chooses the segment size for the whole request: 32 bytes or 128 bytes.

The block has a request stream and a transaction stream, and both use valid/ready. A request is accepted only when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` stays low from acceptance until the request's done pulse. A transaction moves when `txn_valid` and `txn_ready` are both high. While `txn_ready` is low, the presented transaction holds all of its fields unchanged.

The block forms one group per transaction slot. It takes the lowest-numbered enabled lane that has not been served yet, clears that lane's low address bits to get the segment base, and serves every remaining lane with the same base. After the last transaction has been accepted, a one-cycle done pulse reports how many transactions the request produced.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high only while the block is idle: out of reset, and from the cycle after a done pulse. It is low from the cycle after a request is accepted through the cycle of that request's done pulse.
- R2: With `req_wide`=1, a transaction's base is the leading lane's address with bits [6:0] cleared. With `req_wide`=0, bits [4:0] are cleared. `txn_wide` repeats the mode latched with the request.
- R3: Transactions come out in rising order of their lowest-numbered lane. Each one is led by the lowest-numbered enabled lane that has not yet been served.
- R4: Bit i of `txn_mask` is set exactly when lane i is enabled, not yet served, and has the same segment base as the leading lane. Lane i's address sits at bits [32*i+31 : 32*i] of `req_addr`.
- R5: The masks of one request's transactions do not overlap, and together they equal `req_active`.
- R6: Thirty-two enabled lanes reading adjacent words from a 128-byte-aligned address give exactly one transaction in 128-byte mode and four in 32-byte mode.
- R7: Enabled lanes whose addresses all lie in different segments give one transaction per enabled lane.
- R8: A request with `req_active`=0 is accepted and produces no transaction. A done pulse with count 0 follows in the next cycle.
- R9: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base`, `txn_mask` and `txn_wide` hold their values into the next cycle.
- R10: `done` is high for one cycle. That cycle comes one cycle after the last transaction is accepted, or one cycle after an empty request is accepted. In that cycle `done_count` equals the number of transactions the request produced.
- R11: During and right after reset, `req_ready`=1, `txn_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_active | input | 32 | Lane enable bits |
| req_addr | input | 1024 | Per-lane byte addresses, lane i at bits [32*i+31:32*i] |
| req_wide | input | 1 | 1: 128-byte segments, 0: 32-byte segments |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_base | output | 32 | Aligned segment base address |
| txn_wide | output | 1 | Segment size of this transaction |
| txn_mask | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle end-of-request pulse |
| done_count | output | 6 | Transaction count, valid while `done` is high |

## Verification
The directed patterns each isolate one outcome. Fully adjacent words tell the one-transaction 128-byte case apart from the four-transaction 32-byte case. A 128-byte lane stride forces one transaction per lane. An empty mask checks the no-transaction path. Adjacent words starting at an odd 32-byte boundary show whether alignment really clears the low bits, because in 128-byte mode they must split into two transactions. A long sweep of pseudo-random sparse masks, clustered addresses and both modes runs under random downstream stalls. It compares every transaction in order against groupings the bench computes itself, so grouping errors, ordering errors and changes made under back-pressure all become visible.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic {
    CX_IDLE = 1'b0,
    CX_BUSY = 1'b1
  } cx_state_e;
endpackage

// File: rtl/cx_lane_pick.sv
module cx_lane_pick #(
  parameter int LANES = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic [LANES-1:0] pick_oh,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_any
);
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    pick_any = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && !pick_any) begin
        pick_any   = 1'b1;
        pick_oh[i] = 1'b1;
        pick_idx   = IDX_W'(i);
      end
    end
  end

  // R3
  always_comb begin
    lead_onehot_chk: assert ($onehot0(pick_oh));
  end
endmodule

// File: rtl/cx_seg_match.sv
module cx_seg_match #(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int NARROW_BYTES = 32,
  parameter int WIDE_BYTES   = 128,
  localparam int IDX_W       = $clog2(LANES)
) (
  input  logic [LANES*ADDR_W-1:0] addrs,
  input  logic [LANES-1:0]        pend,
  input  logic                    wide,
  input  logic [IDX_W-1:0]        lead_idx,
  output logic [ADDR_W-1:0]       base,
  output logic [LANES-1:0]        mask
);
  localparam logic [ADDR_W-1:0] NARROW_KEEP = ~(ADDR_W'(NARROW_BYTES - 1));
  localparam logic [ADDR_W-1:0] WIDE_KEEP   = ~(ADDR_W'(WIDE_BYTES - 1));

  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] lane_base [LANES];

  assign keep = wide ? WIDE_KEEP : NARROW_KEEP;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_base[g] = addrs[g*ADDR_W +: ADDR_W] & keep;
    assign mask[g]      = pend[g] && (lane_base[g] == base);
  end

  assign base = lane_base[lead_idx];
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int NARROW_BYTES = 32,
  parameter int WIDE_BYTES   = 128,
  localparam int IDX_W       = $clog2(LANES),
  localparam int CNT_W       = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic                    req_wide,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_base,
  output logic                    txn_wide,
  output logic [LANES-1:0]        txn_mask,
  output logic                    done,
  output logic [CNT_W-1:0]        done_count
);
  import cx_pkg::*;

  localparam int NARROW_SH = $clog2(NARROW_BYTES);
  localparam int WIDE_SH   = $clog2(WIDE_BYTES);

  cx_state_e               state_q;
  logic [LANES-1:0]        pend_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic                    wide_q;
  logic [CNT_W-1:0]        cnt_q;

  logic [LANES-1:0] lead_oh;
  logic [IDX_W-1:0] lead_idx;
  logic             lead_any;
  logic [LANES-1:0] grp_mask;
  logic [ADDR_W-1:0] grp_base;
  logic             req_fire;
  logic             txn_fire;

  cx_lane_pick #(.LANES(LANES)) u_pick (
    .pend     (pend_q),
    .pick_oh  (lead_oh),
    .pick_idx (lead_idx),
    .pick_any (lead_any)
  );

  cx_seg_match #(
    .LANES        (LANES),
    .ADDR_W       (ADDR_W),
    .NARROW_BYTES (NARROW_BYTES),
    .WIDE_BYTES   (WIDE_BYTES)
  ) u_match (
    .addrs    (addr_q),
    .pend     (pend_q),
    .wide     (wide_q),
    .lead_idx (lead_idx),
    .base     (grp_base),
    .mask     (grp_mask)
  );

  assign req_ready  = (state_q == CX_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign txn_valid  = (state_q == CX_BUSY) && lead_any;
  assign txn_fire   = txn_valid && txn_ready;
  assign txn_base   = grp_base;
  assign txn_mask   = grp_mask;
  assign txn_wide   = wide_q;
  assign done       = (state_q == CX_BUSY) && !lead_any;
  assign done_count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CX_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      wide_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        CX_IDLE: begin
          if (req_fire) begin
            state_q <= CX_BUSY;
            pend_q  <= req_active;
            addr_q  <= req_addr;
            wide_q  <= req_wide;
            cnt_q   <= '0;
          end
        end
        default: begin
          if (done) begin
            state_q <= CX_IDLE;
          end else if (txn_fire) begin
            pend_q <= pend_q & ~grp_mask;
            cnt_q  <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R4
  lead_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & lead_oh) != '0));

  // R5
  mask_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & ~pend_q) == '0));

  // R2
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_base[NARROW_SH-1:0] == '0) &&
                  (!txn_wide || (txn_base[WIDE_SH-1:0] == '0)));

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> txn_valid && $stable(txn_base) &&
                                  $stable(txn_mask) && $stable(txn_wide));

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid || done) |-> !req_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R5
  served_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fire |=> ((pend_q & $past(txn_mask)) == '0));
endmodule

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  localparam int L = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [L-1:0]  req_active = '0;
  logic [L*32-1:0] req_addr = '0;
  logic          req_wide = 1'b0;
  logic          txn_valid;
  logic          txn_ready = 1'b0;
  logic [31:0]   txn_base;
  logic          txn_wide;
  logic [L-1:0]  txn_mask;
  logic          done;
  logic [5:0]    done_count;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  logic [31:0] a [L];
  logic [31:0] exp_base [L];
  logic [L-1:0] exp_mask [L];
  int exp_n;

  always #5 clk = ~clk;

  warp_coalescer u_warp_coalescer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .req_wide(req_wide),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
    .txn_wide(txn_wide), .txn_mask(txn_mask), .done(done), .done_count(done_count)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // grouping computed from the requirements: lowest unserved lane leads, base clears low bits
  task automatic model(input logic [L-1:0] act, input bit wide);
    logic [L-1:0] left = act;
    logic [31:0] keep = wide ? 32'hFFFF_FF80 : 32'hFFFF_FFE0;
    exp_n = 0;
    for (int i = 0; i < L; i++) begin
      if (left[i]) begin
        exp_base[exp_n] = a[i] & keep;
        exp_mask[exp_n] = '0;
        for (int j = i; j < L; j++)
          if (left[j] && ((a[j] & keep) == exp_base[exp_n])) exp_mask[exp_n][j] = 1'b1;
        left = left & ~exp_mask[exp_n];
        exp_n++;
      end
    end
  endtask

  task automatic run_req(input logic [L-1:0] act, input bit wide, input int stall_pct, input string tag);
    int k = 0;
    int guard = 0;
    logic [L-1:0] seen = '0;
    bit prev_stall = 1'b0;
    logic [31:0] prev_base;
    logic [L-1:0] prev_mask;
    bit fin = 1'b0;
    bit rdy_bad = 1'b0;
    model(act, wide);
    @(negedge clk);
    for (int i = 0; i < L; i++) req_addr[i*32 +: 32] = a[i];
    req_active = act;
    req_wide = wide;
    req_valid = 1'b1;
    #1;
    chk(req_ready === 1'b1, "R1 idle ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!fin && guard < 2000) begin
      guard++;
      txn_ready = (int'(rnd() % 100) >= stall_pct);
      #1;
      if (req_ready) rdy_bad = 1'b1;
      if (prev_stall) begin
        chk(txn_valid && txn_base == prev_base && txn_mask == prev_mask, "R9 hold",
            {txn_base, txn_mask}, {prev_base, prev_mask});
      end
      prev_stall = txn_valid && !txn_ready;
      prev_base = txn_base;
      prev_mask = txn_mask;
      if (done) begin
        fin = 1'b1;
        chk(txn_valid === 1'b0, "R10 no txn at done", 64'(txn_valid), 64'd0);
        chk(int'(done_count) == exp_n, tag, 64'(done_count), 64'(exp_n));
        chk(seen == act, "R5 union", 64'(seen), 64'(act));
      end else if (txn_valid && txn_ready) begin
        if (k < exp_n) begin
          chk(txn_base == exp_base[k], "R2 base", 64'(txn_base), 64'(exp_base[k]));
          chk(txn_mask == exp_mask[k], "R3 R4 mask order", 64'(txn_mask), 64'(exp_mask[k]));
        end else begin
          chk(1'b0, "R10 extra txn", 64'(k), 64'(exp_n));
        end
        chk(txn_wide == wide, "R2 mode", 64'(txn_wide), 64'(wide));
        chk((seen & txn_mask) == '0, "R5 disjoint", 64'(seen & txn_mask), 64'd0);
        seen = seen | txn_mask;
        k++;
      end
      @(negedge clk);
    end
    chk(fin, "R10 done seen", 64'(fin), 64'd1);
    chk(!rdy_bad, "R1 busy not ready", 64'(rdy_bad), 64'd0);
    txn_ready = 1'b0;
    #1;
    chk(req_ready === 1'b1 && done === 1'b0, "R10 single pulse", {req_ready, done}, 2'b10);
  endtask

  initial begin
    #1;
    chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0, "R11 in reset",
        {req_ready, txn_valid, done}, 3'b100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0, "R11 after reset",
        {req_ready, txn_valid, done}, 3'b100);

    for (int i = 0; i < L; i++) a[i] = 32'h0000_1000 + 32'(4 * i);
    run_req('1, 1'b1, 0, "R6 adjacent wide count");
    chk(exp_n == 1, "R6 wide model", 64'(exp_n), 64'd1);
    run_req('1, 1'b0, 30, "R6 adjacent narrow count");
    chk(exp_n == 4, "R6 narrow model", 64'(exp_n), 64'd4);

    for (int i = 0; i < L; i++) a[i] = 32'h0000_2020 + 32'(4 * i);
    run_req('1, 1'b1, 20, "R2 unaligned wide count");
    chk(exp_n == 2, "R2 split model", 64'(exp_n), 64'd2);

    for (int i = 0; i < L; i++) a[i] = 32'h0001_0000 + 32'(128 * (L - 1 - i));
    run_req('1, 1'b1, 40, "R7 scattered count");
    chk(exp_n == 32, "R7 model", 64'(exp_n), 64'd32);
    run_req(32'h8001_0010, 1'b0, 0, "R7 sparse scattered count");

    run_req('0, 1'b1, 0, "R8 empty count");
    run_req('0, 1'b0, 50, "R8 empty narrow count");

    for (int t = 0; t < 300; t++) begin
      logic [L-1:0] act;
      for (int i = 0; i < L; i++) a[i] = 32'h0004_0000 + ((rnd() % 32'd1024) & 32'hFFFF_FFFC);
      act = rnd() & rnd() | ((t % 3 == 0) ? rnd() : '0);
      run_req(act, t[0], int'(t % 4) * 20, "R4 sweep count");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule